// File: doc/BRIEF.md
# Converted Sample Byte DDR Output

This block sits at the digital edge of a three-colour imaging front end. It accepts one 16-bit converted sample for each colour channel and presents each sample on an 8-bit bus. The upper byte is driven while the clock is high and the lower byte while it is low, so a whole sample crosses the bus in one clock period. A pixel strobe marks the start of each pixel. In three-channel mode the block emits red, green and blue on three consecutive clocks after each strobe. In one-channel mode the clock runs at the pixel rate and only the red sample is emitted.

A mode-dependent delay line places each sample at a fixed distance from its strobe. That distance is 12 clocks in three-channel mode and 10 clocks in one-channel mode, which models the conversion pipeline plus the correction registers ahead of it. A valid flag and a 2-bit channel tag go with every emitted sample. A new mode is adopted only on a strobe, and adopting it discards everything still in flight.

Top module: `sample_ddr_out`

## Requirements
- R1: While reset is asserted, out_valid is 0, out_tag is 0 and out_byte is 0 in both clock phases.
- R2: In three-channel mode (mode_sel = 0), a strobe produces three valid samples on consecutive clocks, with tags red = 0, green = 1 and blue = 2, in that order. Tag value 3 never appears.
- R3: After each rising edge, out_byte carries bits 15:8 of the current sample while clk is high and bits 7:0 of the same sample while clk is low.
- R4: In three-channel mode, the red sample captured at strobe edge e becomes the current sample at rising edge e+12. Green follows at e+13 and blue at e+14.
- R5: In one-channel mode (mode_sel = 1), the red sample captured at strobe edge e becomes the current sample at rising edge e+10.
- R6: In one-channel mode, each strobe yields exactly one valid sample, tagged red (0). The green and blue inputs are never emitted.
- R7: The inputs are sampled only at the strobe edge. Changing red_in, grn_in or blu_in after that edge does not alter the samples of that pixel.
- R8: Whenever out_valid is 0, out_tag is 0 and out_byte is 0 in both phases. This includes the pipeline fill after reset and the gaps between pixels.
- R9: A change of mode_sel between strobes has no effect. Sequencing and latency follow the mode latched at the last strobe.
- R10: A strobe whose mode_sel differs from the latched mode clears every sample in flight. out_valid is 0 at the following edge, and no sample of the old mode is ever emitted afterwards.
- R11: A strobe that arrives while a three-channel pixel is still being sequenced restarts the sequence at red with the new inputs. The unfinished colours of the old pixel are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock. Rising and falling halves select the byte. |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_strobe | input | 1 | Pixel sampling strobe, sampled at the rising edge |
| mode_sel | input | 1 | 0 = three-channel, 1 = one-channel; adopted at a strobe |
| red_in | input | 16 | Red converted sample |
| grn_in | input | 16 | Green converted sample |
| blu_in | input | 16 | Blue converted sample |
| out_byte | output | 8 | Output bus: high byte while clk is high, low byte while clk is low |
| out_tag | output | 2 | Channel tag of the current sample |
| out_valid | output | 1 | Current sample holds real data |

## Verification
Two events can land on the same rising edge: the flush caused by a mode change and the loading of the new pixel's red sample into the head of the delay line. Samples of the old pixel are then still in the stages and due to emerge at the old latency.

The bench provokes this by issuing a three-channel strobe and then, four clocks later, a one-channel strobe. The old red sample would have surfaced two edges before the new red sample is due. The run is judged by requiring the output to stay invalid for every edge up to the new one-channel latency, and then to show the new red sample exactly at that edge.

A second collision is a strobe arriving one clock after another in three-channel mode. Here the bench expects both red samples back to back, followed only by the second pixel's green and blue.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;

   typedef enum logic [1:0] {
      CH_RED  = 2'd0,
      CH_GRN  = 2'd1,
      CH_BLU  = 2'd2,
      CH_NONE = 2'd3
   } chan_e;

   typedef enum logic {
      MODE_TRI  = 1'b0,
      MODE_MONO = 1'b1
   } mode_e;

   typedef enum logic [1:0] {
      SL_IDLE = 2'd0,
      SL_GRN  = 2'd1,
      SL_BLU  = 2'd2
   } slot_e;

   // extra clocks on top of the converter pipeline for each mode
   localparam int TRI_EXTRA  = 3;
   localparam int MONO_EXTRA = 1;

endpackage

// File: rtl/ddr_slot_seq.sv
module ddr_slot_seq
   import ddr_out_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              mode_sel,
   input  logic [DATA_W-1:0] red,
   input  logic [DATA_W-1:0] grn,
   input  logic [DATA_W-1:0] blu,
   output logic              ent_v,
   output logic [1:0]        ent_tag,
   output logic [DATA_W-1:0] ent_d,
   output logic              flush,
   output logic              mode_act
);

   slot_e             slot_q;
   logic [DATA_W-1:0] hold_g;
   logic [DATA_W-1:0] hold_b;

   // a strobe that brings a different mode discards the pipeline
   assign flush = strobe && (mode_sel != mode_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= SL_IDLE;
         mode_act <= MODE_TRI;
         hold_g   <= '0;
         hold_b   <= '0;
         ent_v    <= 1'b0;
         ent_tag  <= CH_RED;
         ent_d    <= '0;
      end else if (strobe) begin
         mode_act <= mode_sel;
         hold_g   <= grn;
         hold_b   <= blu;
         ent_v    <= 1'b1;
         ent_tag  <= CH_RED;
         ent_d    <= red;
         slot_q   <= (mode_sel == MODE_MONO) ? SL_IDLE : SL_GRN;
      end else begin
         case (slot_q)
            SL_GRN: begin
               ent_v   <= 1'b1;
               ent_tag <= CH_GRN;
               ent_d   <= hold_g;
               slot_q  <= SL_BLU;
            end
            SL_BLU: begin
               ent_v   <= 1'b1;
               ent_tag <= CH_BLU;
               ent_d   <= hold_b;
               slot_q  <= SL_IDLE;
            end
            default: begin
               ent_v   <= 1'b0;
               ent_tag <= CH_RED;
               ent_d   <= '0;
               slot_q  <= SL_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/ddr_lat_line.sv
module ddr_lat_line
   import ddr_out_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 11,
   parameter int TAP_MONO = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              mode_act,
   input  logic              in_v,
   input  logic [1:0]        in_tag,
   input  logic [DATA_W-1:0] in_d,
   output logic              tap_v,
   output logic [1:0]        tap_tag,
   output logic [DATA_W-1:0] tap_d
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ddr_lat_line: DEPTH must be at least 1");
   end
   if (TAP_MONO < 1 || TAP_MONO > DEPTH) begin : g_bad_tap
      $error("ddr_lat_line: TAP_MONO must lie in 1..DEPTH");
   end

   for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
      logic              pv;
      logic [1:0]        pt;
      logic [DATA_W-1:0] pd;
      logic              v_q;
      logic [1:0]        t_q;
      logic [DATA_W-1:0] d_q;

      if (i == 1) begin : g_head
         assign pv = in_v;
         assign pt = in_tag;
         assign pd = in_d;
      end else begin : g_body
         assign pv = g_stage[i-1].v_q;
         assign pt = g_stage[i-1].t_q;
         assign pd = g_stage[i-1].d_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= CH_RED;
            d_q <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
            t_q <= CH_RED;
            d_q <= '0;
         end else begin
            v_q <= pv;
            t_q <= pt;
            d_q <= pd;
         end
      end
   end

   if (TAP_MONO == DEPTH) begin : g_single_tap
      assign tap_v   = g_stage[DEPTH].v_q;
      assign tap_tag = g_stage[DEPTH].t_q;
      assign tap_d   = g_stage[DEPTH].d_q;
   end else begin : g_dual_tap
      always_comb begin
         if (mode_act == MODE_MONO) begin
            tap_v   = g_stage[TAP_MONO].v_q;
            tap_tag = g_stage[TAP_MONO].t_q;
            tap_d   = g_stage[TAP_MONO].d_q;
         end else begin
            tap_v   = g_stage[DEPTH].v_q;
            tap_tag = g_stage[DEPTH].t_q;
            tap_d   = g_stage[DEPTH].d_q;
         end
      end
   end

endmodule

// File: rtl/ddr_byte_out.sv
module ddr_byte_out
   import ddr_out_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit HI_ON_RISE = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                tap_v,
   input  logic [1:0]          tap_tag,
   input  logic [DATA_W-1:0]   tap_d,
   output logic                valid_q,
   output logic [1:0]          tag_q,
   output logic [DATA_W-1:0]   word_q,
   output logic [DATA_W/2-1:0] out_byte
);

   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] hi_half;
   logic [HALF_W-1:0] lo_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= CH_RED;
         word_q  <= '0;
      end else if (flush) begin
         valid_q <= 1'b0;
         tag_q   <= CH_RED;
         word_q  <= '0;
      end else begin
         valid_q <= tap_v;
         tag_q   <= tap_v ? tap_tag : CH_RED;
         word_q  <= tap_v ? tap_d : '0;
      end
   end

   assign hi_half = word_q[DATA_W-1:HALF_W];
   assign lo_half = word_q[HALF_W-1:0];

   // both halves come from one registered word; the clock level picks the half
   if (HI_ON_RISE) begin : g_hi_first
      assign out_byte = clk ? hi_half : lo_half;
   end else begin : g_lo_first
      assign out_byte = clk ? lo_half : hi_half;
   end

endmodule

// File: rtl/sample_ddr_out.sv
module sample_ddr_out
   import ddr_out_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CONV_LAT   = 9,
   parameter bit HI_ON_RISE = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_strobe,
   input  logic                mode_sel,
   input  logic [DATA_W-1:0]   red_in,
   input  logic [DATA_W-1:0]   grn_in,
   input  logic [DATA_W-1:0]   blu_in,
   output logic [DATA_W/2-1:0] out_byte,
   output logic [1:0]          out_tag,
   output logic                out_valid
);

   localparam int LAT_TRI    = CONV_LAT + TRI_EXTRA;
   localparam int LAT_MONO   = CONV_LAT + MONO_EXTRA;
   localparam int LINE_DEPTH = LAT_TRI - 1;
   localparam int TAP_MONO   = LAT_MONO - 1;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("sample_ddr_out: DATA_W must be even and at least 2");
   end
   if (CONV_LAT < 1) begin : g_bad_lat
      $error("sample_ddr_out: CONV_LAT must be at least 1");
   end

   logic              ent_v;
   logic [1:0]        ent_tag;
   logic [DATA_W-1:0] ent_d;
   logic              flush_w;
   logic              mode_act_w;
   logic              tap_v;
   logic [1:0]        tap_tag;
   logic [DATA_W-1:0] tap_d;
   logic [DATA_W-1:0] word_q;

   ddr_slot_seq #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (pix_strobe),
      .mode_sel (mode_sel),
      .red      (red_in),
      .grn      (grn_in),
      .blu      (blu_in),
      .ent_v    (ent_v),
      .ent_tag  (ent_tag),
      .ent_d    (ent_d),
      .flush    (flush_w),
      .mode_act (mode_act_w)
   );

   ddr_lat_line #(
      .DATA_W   (DATA_W),
      .DEPTH    (LINE_DEPTH),
      .TAP_MONO (TAP_MONO)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_w),
      .mode_act (mode_act_w),
      .in_v     (ent_v),
      .in_tag   (ent_tag),
      .in_d     (ent_d),
      .tap_v    (tap_v),
      .tap_tag  (tap_tag),
      .tap_d    (tap_d)
   );

   ddr_byte_out #(
      .DATA_W     (DATA_W),
      .HI_ON_RISE (HI_ON_RISE)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_w),
      .tap_v    (tap_v),
      .tap_tag  (tap_tag),
      .tap_d    (tap_d),
      .valid_q  (out_valid),
      .tag_q    (out_tag),
      .word_q   (word_q),
      .out_byte (out_byte)
   );

endmodule

// File: rtl/ddr_out_chk.sv
module ddr_out_chk
   import ddr_out_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic [1:0]        out_tag,
   input logic [DATA_W-1:0] word_q,
   input logic              flush,
   input logic              mode_act
);

   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (word_q == '0 && out_tag == CH_RED));

   assert_no_tag3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_tag != CH_NONE);

   assert_grn_after_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tag == CH_GRN) |-> ($past(out_valid) && $past(out_tag) == CH_RED));

   assert_blu_after_grn_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tag == CH_BLU) |-> ($past(out_valid) && $past(out_tag) == CH_GRN));

   assert_mono_red_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == MODE_MONO && out_valid) |-> out_tag == CH_RED);

   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

endmodule

bind sample_ddr_out ddr_out_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_tag   (out_tag),
   .word_q    (word_q),
   .flush     (flush_w),
   .mode_act  (mode_act_w)
);

// File: tb/sample_ddr_out_tb.sv
`timescale 1ns/1ps
module sample_ddr_out_tb;

   localparam real CLK_PER = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_strobe = 1'b0;
   logic        mode_sel = 1'b0;
   logic [15:0] red_in = '0;
   logic [15:0] grn_in = '0;
   logic [15:0] blu_in = '0;
   logic [7:0]  out_byte;
   logic [1:0]  out_tag;
   logic        out_valid;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   sample_ddr_out u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_strobe (pix_strobe),
      .mode_sel   (mode_sel),
      .red_in     (red_in),
      .grn_in     (grn_in),
      .blu_in     (blu_in),
      .out_byte   (out_byte),
      .out_tag    (out_tag),
      .out_valid  (out_valid)
   );

   task automatic check(input string req, input string what,
                        input logic ev, input logic [1:0] et, input logic [7:0] eb);
      n_chk++;
      if (out_valid !== ev || out_tag !== et || out_byte !== eb) begin
         n_fail++;
         $display("FAIL %s %s: got valid=%0b tag=%0d byte=%h, expected valid=%0b tag=%0d byte=%h",
                  req, what, out_valid, out_tag, out_byte, ev, et, eb);
      end
   endtask

   // advance one rising edge, check high phase then low phase (R3)
   task automatic step_check(input string req, input logic ev,
                             input logic [1:0] et, input logic [15:0] ew);
      @(posedge clk); #1;
      check(req, "R3 high phase", ev, et, ew[15:8]);
      @(negedge clk); #1;
      check(req, "R3 low phase", ev, et, ew[7:0]);
   endtask

   task automatic expect_idle(input string req, input int n);
      for (int k = 0; k < n; k++) step_check(req, 1'b0, 2'd0, 16'h0000);
   endtask

   task automatic strobe(input logic m, input logic [15:0] r,
                         input logic [15:0] g, input logic [15:0] b);
      pix_strobe = 1'b1;
      mode_sel   = m;
      red_in     = r;
      grn_in     = g;
      blu_in     = b;
      @(posedge clk); #1;
      pix_strobe = 1'b0;
   endtask

   task automatic drain();
      repeat (16) @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      check("R1", "reset high phase", 1'b0, 2'd0, 8'h00);
      @(negedge clk); #1;
      check("R1", "reset low phase", 1'b0, 2'd0, 8'h00);
      rst_n = 1'b1;
   endtask

   task automatic t_three_chan();
      strobe(1'b0, 16'hA1B2, 16'hC3D4, 16'hE5F6);
      expect_idle("R4 fill R8", 11);
      step_check("R4 red", 1'b1, 2'd0, 16'hA1B2);
      step_check("R2 green", 1'b1, 2'd1, 16'hC3D4);
      step_check("R2 blue", 1'b1, 2'd2, 16'hE5F6);
      expect_idle("R8 gap", 2);
      drain();
   endtask

   task automatic t_one_chan();
      strobe(1'b1, 16'h5A3C, 16'h1111, 16'h2222);
      expect_idle("R5 fill", 9);
      step_check("R5 red", 1'b1, 2'd0, 16'h5A3C);
      expect_idle("R6 no green/blue", 3);
      strobe(1'b1, 16'h7E81, 16'h3333, 16'h4444);
      expect_idle("R5 fill again", 9);
      step_check("R5 second red", 1'b1, 2'd0, 16'h7E81);
      expect_idle("R6 no green/blue again", 3);
      drain();
   endtask

   task automatic t_hold();
      strobe(1'b0, 16'h0F1E, 16'h2D3C, 16'h4B5A);
      red_in = 16'hFFFF;
      grn_in = 16'hEEEE;
      blu_in = 16'hDDDD;
      expect_idle("R7 fill", 11);
      step_check("R7 red held", 1'b1, 2'd0, 16'h0F1E);
      step_check("R7 green held", 1'b1, 2'd1, 16'h2D3C);
      step_check("R7 blue held", 1'b1, 2'd2, 16'h4B5A);
      drain();
   endtask

   task automatic t_mode_ignore();
      strobe(1'b0, 16'h1357, 16'h2468, 16'h9BDF);
      mode_sel = 1'b1;
      expect_idle("R9 mono latency not taken", 11);
      step_check("R9 red", 1'b1, 2'd0, 16'h1357);
      step_check("R9 green", 1'b1, 2'd1, 16'h2468);
      step_check("R9 blue", 1'b1, 2'd2, 16'h9BDF);
      mode_sel = 1'b0;
      drain();
   endtask

   task automatic t_flush();
      strobe(1'b0, 16'hAAAA, 16'hBBBB, 16'hCCCC);
      expect_idle("R10 before switch", 3);
      strobe(1'b1, 16'h6C6C, 16'h0000, 16'h0000);
      expect_idle("R10 old samples dropped", 9);
      step_check("R10 new red", 1'b1, 2'd0, 16'h6C6C);
      expect_idle("R10 after", 3);
      mode_sel = 1'b0;
      drain();
   endtask

   task automatic t_restart();
      strobe(1'b0, 16'h1001, 16'h1002, 16'h1003);
      strobe(1'b0, 16'h2001, 16'h2002, 16'h2003);
      expect_idle("R11 fill", 10);
      step_check("R11 first red", 1'b1, 2'd0, 16'h1001);
      step_check("R11 second red", 1'b1, 2'd0, 16'h2001);
      step_check("R11 second green", 1'b1, 2'd1, 16'h2002);
      step_check("R11 second blue", 1'b1, 2'd2, 16'h2003);
      expect_idle("R11 after", 2);
      drain();
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      @(negedge clk); #1;
      t_three_chan();
      t_one_chan();
      t_hold();
      t_mode_ignore();
      t_flush();
      t_restart();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule